// File: doc/BRIEF.md
# Half-Rate Clock Domain Transfer Bridge

This block moves data words between a fast clock and a slow clock that it derives itself by halving the fast clock. All of its registers run on the fast clock. The block also drives a strobe that marks the fast cycles whose closing edge is a rising edge of the slow clock. Because the 2:1 relation is fixed and the strobe phase is known in advance, both directions are crossed with single gated registers and no chain of synchronizing flops. The scheme is only valid for this exact ratio.

In the fast-to-slow direction, a fast producer offers a word with a valid bit in any cycle. A word offered in a strobe cycle is loaded into the output register at that edge. A word offered in the other phase is parked for one cycle and loaded at the next strobe edge. The output register changes only at slow rising edges, so each slow edge samples a value that has been stable for a full slow period. In the slow-to-fast direction, the slow domain launches a word at a slow rising edge. The bridge captures it only at the following strobe edge and presents it to the fast domain as a one-cycle valid pulse.

Top module: `half_rate_xfer`

## Requirements
- R1: `clk_slow` is 0 during reset and toggles at every fast rising edge afterwards, so its first rising edge is the first fast edge after reset is released.
- R2: `sync_o` is 1 during reset, alternates every fast cycle, and is high exactly in the fast cycles where `clk_slow` is 0, which are the cycles whose closing edge raises `clk_slow`.
- R3: A fast-to-slow word offered in a cycle with `sync_o` = 1 appears on `fs_data_o` with `fs_valid_o` = 1 in the next fast cycle and is held for two fast cycles, so the slow domain samples it at exactly one slow rising edge (2 fast cycles after the offer cycle).
- R4: A fast-to-slow word offered in a cycle with `sync_o` = 0 is held internally for one cycle and appears on the outputs two fast cycles after the offer cycle, so it is sampled by the slow domain 3 fast cycles after the offer cycle, exactly once.
- R5: `fs_valid_o` and `fs_data_o` change only at fast edges that close a `sync_o` = 1 cycle, and `fs_valid_o` returns to 0 at such an edge when no word is loaded.
- R6: Slow-to-fast inputs are sampled only at fast edges that close a `sync_o` = 1 cycle. Values present at the other edges, including a valid of 1, have no effect on the outputs.
- R7: Each captured slow-to-fast word gives `sf_valid_o` = 1 for exactly one fast cycle, the cycle after the capture edge (a `sync_o` = 0 cycle). `sf_data_o` holds the last captured word until the next capture.
- R8: Reset (active-low, asynchronous) clears the divider phase, the strobe generator, the parked fast-to-slow word and all transfer registers. A parked word is discarded.
- R9: The fast producer offers at most one word per transfer window, a window being a `sync_o` = 0 cycle together with the `sync_o` = 1 cycle that follows it. Valid bits are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; every register of the block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_slow | output | 1 | Fast clock divided by two |
| sync_o | output | 1 | High in fast cycles whose closing edge raises clk_slow |
| fs_valid_i | input | 1 | Fast producer offers a word this cycle |
| fs_data_i | input | DATA_W | Fast-to-slow word |
| fs_valid_o | output | 1 | Word for the slow domain is valid (held one slow period) |
| fs_data_o | output | DATA_W | Word for the slow domain |
| sf_valid_i | input | 1 | Slow domain offers a word (launched at slow rising edge) |
| sf_data_i | input | DATA_W | Slow-to-fast word |
| sf_valid_o | output | 1 | One-cycle pulse: captured word is available to the fast domain |
| sf_data_o | output | DATA_W | Last captured slow-to-fast word |

## Verification
The fast-to-slow path is driven through a sweep of offer spacings from one to five cycles. Because the spacings step through odd and even values, words land in both strobe phases and in every spacing relative to the strobe. This separates the direct-load latency from the parked-word latency, and a word that is lost, duplicated or loaded at the wrong edge shows up as a mismatch. The slow-to-fast path is driven with a repeating pattern of valid and idle slow periods. In each period a deliberately wrong value with valid set is placed on the inputs across the off-phase edge, so capture at a wrong edge or a stretched pulse is detected. A reset asserted while a word is parked checks that the word is discarded and that the divider phase restarts.

// File: rtl/half_rate_pkg.sv
package half_rate_pkg;

    // Divider and strobe state; the strobe leads the slow rising edge by one fast cycle
    typedef struct packed {
        logic div;
        logic sync;
    } phase_t;

    localparam phase_t PHASE_RST = '{div: 1'b0, sync: 1'b1};

endpackage

// File: rtl/half_rate_phase.sv
module half_rate_phase
    import half_rate_pkg::*;
(
    input  logic clk_fast,
    input  logic rst_n,
    output logic clk_slow,
    output logic sync_o
);

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d      = ph_q;
        ph_d.div  = ~ph_q.div;
        ph_d.sync = ~ph_q.sync;
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) ph_q <= PHASE_RST;
        else        ph_q <= ph_d;
    end

    assign clk_slow = ph_q.div;
    assign sync_o   = ph_q.sync;

    // R1: the slow clock rises only at an edge closing a strobe cycle
    p_slow_rise_r1: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(ph_q.div) |-> $past(ph_q.sync));

    // R2: the strobe alternates
    p_sync_alt_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ph_q.sync |=> !ph_q.sync);

endmodule

// File: rtl/half_rate_f2s.sv
module half_rate_f2s #(
    parameter int DATA_W = 8
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              park;
        logic [DATA_W-1:0] park_data;
        logic              out_v;
        logic [DATA_W-1:0] out_data;
    } f2s_t;

    f2s_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            // Slow rising edge: load the parked word or the word offered now
            st_d.out_v = st_q.park | valid_i;
            if (st_q.park)    st_d.out_data = st_q.park_data;
            else if (valid_i) st_d.out_data = data_i;
            st_d.park = 1'b0;
        end else if (valid_i) begin
            // Off-phase offer: hold it until the next strobe edge
            st_d.park      = 1'b1;
            st_d.park_data = data_i;
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.out_v;
    assign data_o  = st_q.out_data;

    // R5: outputs are stable across off-phase edges
    p_hold_r5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !sync_i |=> ($stable(st_q.out_v) && $stable(st_q.out_data)));

    // R4: a parked word is always followed by a strobe cycle
    p_park_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        st_q.park |-> sync_i);

    // R9: no second offer in the window of a parked word
    p_one_per_window_r9: assert property (@(posedge clk_fast) disable iff (!rst_n)
        st_q.park |-> !valid_i);

endmodule

// File: rtl/half_rate_s2f.sv
module half_rate_s2f #(
    parameter int DATA_W = 8
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] data;
    } s2f_t;

    s2f_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = sync_i & valid_i;
        if (sync_i && valid_i) st_d.data = data_i;
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.v;
    assign data_o  = st_q.data;

    // R7: the pulse lands in an off-phase cycle and lasts one cycle
    p_pulse_phase_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        st_q.v |-> !sync_i);

    p_pulse_once_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        st_q.v |=> !st_q.v);

    // R6: nothing is captured at an off-phase edge
    p_no_offphase_capture_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !sync_i |=> ($stable(st_q.data) && !st_q.v));

endmodule

// File: rtl/half_rate_xfer.sv
module half_rate_xfer #(
    parameter int DATA_W = 8
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    output logic              clk_slow,
    output logic              sync_o,
    input  logic              fs_valid_i,
    input  logic [DATA_W-1:0] fs_data_i,
    output logic              fs_valid_o,
    output logic [DATA_W-1:0] fs_data_o,
    input  logic              sf_valid_i,
    input  logic [DATA_W-1:0] sf_data_i,
    output logic              sf_valid_o,
    output logic [DATA_W-1:0] sf_data_o
);

    logic strobe;

    half_rate_phase phase_i (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .clk_slow (clk_slow),
        .sync_o   (strobe)
    );

    assign sync_o = strobe;

    half_rate_f2s #(.DATA_W(DATA_W)) f2s_i (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .sync_i   (strobe),
        .valid_i  (fs_valid_i),
        .data_i   (fs_data_i),
        .valid_o  (fs_valid_o),
        .data_o   (fs_data_o)
    );

    half_rate_s2f #(.DATA_W(DATA_W)) s2f_i (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .sync_i   (strobe),
        .valid_i  (sf_valid_i),
        .data_i   (sf_data_i),
        .valid_o  (sf_valid_o),
        .data_o   (sf_data_o)
    );

    // R2: strobe and slow clock are in opposite levels
    p_sync_vs_slow_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        sync_o == !clk_slow);

    // R3: a new fast-to-slow word appears only in the cycle after a strobe cycle
    p_fs_new_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(fs_valid_o) |-> $past(sync_o));

endmodule

// File: tb/half_rate_xfer_tb.sv
`timescale 1ns/1ps
module half_rate_xfer_tb_top;

    localparam int DW = 8;

    logic          clk_fast = 1'b0;
    logic          rst_n    = 1'b0;
    logic          clk_slow, sync_o;
    logic          fs_valid_i = 1'b0;
    logic [DW-1:0] fs_data_i  = '0;
    logic          fs_valid_o;
    logic [DW-1:0] fs_data_o;
    logic          sf_valid_i = 1'b0;
    logic [DW-1:0] sf_data_i  = '0;
    logic          sf_valid_o;
    logic [DW-1:0] sf_data_o;

    always #2 clk_fast = ~clk_fast;

    half_rate_xfer #(.DATA_W(DW)) dut_i (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .clk_slow   (clk_slow),
        .sync_o     (sync_o),
        .fs_valid_i (fs_valid_i),
        .fs_data_i  (fs_data_i),
        .fs_valid_o (fs_valid_o),
        .fs_data_o  (fs_data_o),
        .sf_valid_i (sf_valid_i),
        .sf_data_i  (sf_data_i),
        .sf_valid_o (sf_valid_o),
        .sf_data_o  (sf_data_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always @(posedge clk_fast) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard for the fast-to-slow direction: slow-sample cycle and word
    int            cap_q[$];
    logic [DW-1:0] dat_q[$];
    bit            off_q[$];

    // Slow-to-fast model: word launched one slow period ago
    bit            s_prev_v;
    logic [DW-1:0] s_prev_d;
    bit            have_prev_slow;
    logic          prev_slow;
    int            gap_left;
    int            f_n;
    int            s_k;

    task automatic clear_model();
        cap_q.delete(); dat_q.delete(); off_q.delete();
        s_prev_v = 1'b0; s_prev_d = '0;
        have_prev_slow = 1'b0;
        gap_left = 0;
    endtask

    task automatic check_reset_state();
        check(clk_slow == 1'b0,   "R8 clk_slow after reset", clk_slow, 0);
        check(sync_o == 1'b1,     "R8 sync_o after reset", sync_o, 1);
        check(fs_valid_o == 1'b0, "R8 fs_valid_o after reset", fs_valid_o, 0);
        check(fs_data_o == '0,    "R8 fs_data_o after reset", fs_data_o, 0);
        check(sf_valid_o == 1'b0, "R8 sf_valid_o after reset", sf_valid_o, 0);
        check(sf_data_o == '0,    "R8 sf_data_o after reset", sf_data_o, 0);
    endtask

    // One fast cycle: check at the falling edge, then drive the next inputs
    task automatic step(input bit send_en);
        bit            exp_v;
        logic [DW-1:0] exp_d;
        @(negedge clk_fast);
        // R1 / R2: divider and strobe
        if (have_prev_slow)
            check(clk_slow == !prev_slow, "R1 clk_slow toggles", clk_slow, !prev_slow);
        check(sync_o == !clk_slow, "R2 sync_o opposite clk_slow", sync_o, !clk_slow);
        prev_slow = clk_slow;
        have_prev_slow = 1'b1;

        // Fast-to-slow: slow domain samples at the end of strobe cycles
        exp_v = 1'b0; exp_d = '0;
        if (sync_o) begin
            if (cap_q.size() != 0 && cap_q[0] == cyc) begin
                exp_v = 1'b1; exp_d = dat_q[0];
                check(fs_valid_o == 1'b1, off_q[0] ? "R4 parked word sampled" : "R3 word sampled",
                      fs_valid_o, 1);
                check(fs_data_o == exp_d, off_q[0] ? "R4 parked data" : "R3 data",
                      fs_data_o, exp_d);
                void'(cap_q.pop_front()); void'(dat_q.pop_front()); void'(off_q.pop_front());
            end else begin
                check(fs_valid_o == 1'b0, "R5 no word at slow sample", fs_valid_o, 0);
            end
        end else begin
            exp_v = (cap_q.size() != 0 && cap_q[0] == cyc + 1);
            check(fs_valid_o == exp_v, "R5 fs_valid_o in off-phase cycle", fs_valid_o, exp_v);
            if (exp_v)
                check(fs_data_o == dat_q[0], "R5 fs_data_o held", fs_data_o, dat_q[0]);
        end

        // Slow-to-fast: pulse only in off-phase cycles, one slow period after launch
        if (sync_o) begin
            check(sf_valid_o == 1'b0, "R7 no pulse in strobe cycle", sf_valid_o, 0);
        end else begin
            check(sf_valid_o == s_prev_v, "R6 sf_valid_o", sf_valid_o, s_prev_v);
            if (s_prev_v)
                check(sf_data_o == s_prev_d, "R7 sf_data_o", sf_data_o, s_prev_d);
        end

        // Drive fast-to-slow offer
        fs_valid_i = 1'b0;
        if (send_en) begin
            if (gap_left == 0) begin
                fs_valid_i = 1'b1;
                fs_data_i  = 8'(f_n * 29 + 3);
                cap_q.push_back(sync_o ? cyc + 2 : cyc + 3);
                dat_q.push_back(fs_data_i);
                off_q.push_back(!sync_o);
                gap_left = 1 + (f_n % 5);
                // R9: a spacing of one is only legal from a strobe cycle
                if (gap_left == 1 && !sync_o) gap_left = 2;
                f_n++;
            end
            gap_left--;
        end

        // Drive slow-to-fast word: wrong value across the off-phase edge, real one after it
        if (!sync_o) begin
            bit            nv;
            logic [DW-1:0] nd;
            nv = send_en && ((s_k % 3) != 1);
            nd = 8'(s_k * 53 + 11);
            s_k++;
            sf_valid_i = 1'b1;
            sf_data_i  = ~nd;
            @(posedge clk_fast);
            #1;
            sf_valid_i = nv;
            sf_data_i  = nd;
            s_prev_v = nv;
            s_prev_d = nd;
        end
    endtask

    initial begin
        f_n = 0; s_k = 0;
        clear_model();
        prev_slow = 1'b0;
        repeat (3) @(negedge clk_fast);
        rst_n = 1'b1;
        // Reset state before the first fast edge after release (R8, R1, R2)
        #0.5;
        check_reset_state();

        for (int i = 0; i < 3000; i++) step(1'b1);
        // Drain
        for (int i = 0; i < 8; i++) step(1'b0);
        check(cap_q.size() == 0, "R3 every word delivered once", cap_q.size(), 0);

        // Reset while a word is parked (R8)
        wait (sync_o == 1'b1);
        @(negedge clk_fast);
        if (sync_o) @(negedge clk_fast);
        fs_valid_i = 1'b1;
        fs_data_i  = 8'hA5;
        @(negedge clk_fast);
        fs_valid_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk_fast);
        rst_n = 1'b1;
        #0.5;
        clear_model();
        check_reset_state();
        for (int i = 0; i < 10; i++) step(1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule